// File: doc/BRIEF.md
# Thermometer Interval Detector

This block sits behind the comparator bank of a flash converter while that converter is being calibrated. It takes the whole thermometer vector and picks a window of 16 neighbouring comparators from it. It then decides which of 16 voltage intervals the present sample falls in, and reports that interval as a registered one-hot code. A histogram stage downstream counts these codes per interval, and a calibration engine compares the counts with the counts it expects from a test signal of known amplitude distribution.

The window is chosen by a segment index. Segment g starts at comparator `g*STEP`, and the last window is pinned to the top of the bank. Adjacent windows share one comparator, so that their interval boundaries line up. The segment index is captured only while the output strobe is low, so a window cannot move in the middle of an acquisition.

With small offsets the window holds a clean pattern: a run of ones at the bottom and zeros above it. With large offsets the intervals overlap and ones and zeros appear out of order. The detector still produces exactly one interval in that case, chosen from the number of ones, and it records that a correction took place in a sticky flag.

Top module: `thermo_interval_det`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `code` = 16'h0001, `code_valid` = 0 and `overlap_seen` = 0.
- R2: The window is bits `therm[start +: 16]`, where `start` = min(seg*15, N_CMP-16) and seg is the captured segment. Bit j of the window is the j-th comparator counted from the bottom.
- R3: For a clean window (k ones in bits 0..k-1 and zeros above), `code` has bit k set for k = 0..15. For k = 16 it has bit 15 set. Bit i of `code` names interval I(i+1).
- R4: For a window that is not clean, `code` has bit min(number of ones, 15) set.
- R5: `code` and `code_valid` reflect the inputs sampled at the previous rising edge. `code_valid` equals `cal_en` from one cycle earlier.
- R6: `seg_sel` is captured at a rising edge only when `code_valid` is low. While `code_valid` is high, changes on `seg_sel` do not change which window is used.
- R7: A `seg_sel` value above the last segment (4 with default parameters) selects the last window, which starts at comparator N_CMP-16.
- R8: `overlap_seen` goes high one cycle after a window that is not clean is sampled with `cal_en` high, and it stays high until reset. A window that is not clean and is sampled with `cal_en` low leaves it unchanged.
- R9: Exactly one bit of `code` is set in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_en | input | 1 | Calibration mode; samples taken while high are strobed |
| seg_sel | input | SEGW (3) | Segment index that chooses the 16-comparator window |
| therm | input | N_CMP (63) | Full comparator thermometer vector, bit 0 lowest reference |
| code | output | 16 | One-hot interval code |
| code_valid | output | 1 | Strobe for `code` |
| overlap_seen | output | 1 | Sticky flag: a non-thermometer pattern was corrected |

## Verification
The hardest case to reach from the ports is a change of window selection that races an active acquisition. The bench drops `cal_en`, lets the strobe fall, moves `seg_sel`, and then raises calibration again. Afterwards it toggles `seg_sel` while the strobe is high and shows that the window stays put. Bubbles are placed close to the window edges and are also offered with `cal_en` low, which shows that the sticky flag ignores samples taken outside calibration.

// File: rtl/tid_pkg.sv
package tid_pkg;

    localparam int WIN  = 16;
    localparam int IDXW = $clog2(WIN);
    localparam int CNTW = $clog2(WIN + 1);

    typedef logic [WIN-1:0]  win_t;
    typedef logic [IDXW-1:0] idx_t;
    typedef logic [CNTW-1:0] cnt_t;

    typedef struct packed {
        idx_t idx;
        logic clean;
    } resolve_t;

    function automatic cnt_t count_ones(input win_t w);
        cnt_t c;
        c = '0;
        for (int i = 0; i < WIN; i++) begin
            c = c + cnt_t'(w[i]);
        end
        return c;
    endfunction

    // A clean pattern plus one carries into the single next bit only.
    function automatic logic is_clean(input win_t w);
        logic [WIN:0] ext;
        logic [WIN:0] inc;
        ext = {1'b0, w};
        inc = ext + 1'b1;
        return ((ext & inc) == '0);
    endfunction

    function automatic win_t to_onehot(input idx_t i);
        return win_t'(1) << i;
    endfunction

endpackage

// File: rtl/tid_window_mux.sv
module tid_window_mux
    import tid_pkg::*;
#(
    parameter int N_CMP = 63,
    parameter int STEP  = 15,
    parameter int NSEG  = 5,
    parameter int SEGW  = 3
) (
    input  logic [N_CMP-1:0] therm,
    input  logic [SEGW-1:0]  seg,
    output win_t             win
);

    localparam int TOP_START = N_CMP - WIN;

    win_t cand [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        localparam int START = (g * STEP > TOP_START) ? TOP_START : g * STEP;
        assign cand[g] = therm[START +: WIN];
    end

    always_comb begin
        win = '0;
        for (int g = 0; g < NSEG; g++) begin
            if (seg == SEGW'(g)) begin
                win = cand[g];
            end
        end
    end

endmodule

// File: rtl/tid_code_resolver.sv
module tid_code_resolver
    import tid_pkg::*;
(
    input  win_t     win,
    output resolve_t res
);

    cnt_t ones;

    always_comb begin
        ones      = count_ones(win);
        res.clean = is_clean(win);
        if (ones >= cnt_t'(WIN)) begin
            res.idx = idx_t'(WIN - 1);
        end else begin
            res.idx = idx_t'(ones);
        end
    end

endmodule

// File: rtl/thermo_interval_det.sv
module thermo_interval_det
    import tid_pkg::*;
#(
    parameter  int N_CMP = 63,
    parameter  int STEP  = 15,
    localparam int NSEG  = (N_CMP - WIN + STEP - 1) / STEP + 1,
    localparam int SEGW  = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cal_en,
    input  logic [SEGW-1:0]  seg_sel,
    input  logic [N_CMP-1:0] therm,
    output logic [WIN-1:0]   code,
    output logic             code_valid,
    output logic             overlap_seen
);

    logic [SEGW-1:0] seg_q;
    logic [SEGW-1:0] seg_in;
    win_t            win;
    resolve_t        res;
    win_t            code_q;
    logic            valid_q;
    logic            ovl_q;

    assign seg_in = (seg_sel > SEGW'(NSEG - 1)) ? SEGW'(NSEG - 1) : seg_sel;

    tid_window_mux #(
        .N_CMP (N_CMP),
        .STEP  (STEP),
        .NSEG  (NSEG),
        .SEGW  (SEGW)
    ) u_mux (
        .therm (therm),
        .seg   (seg_q),
        .win   (win)
    );

    tid_code_resolver u_res (
        .win (win),
        .res (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q  <= win_t'(1);
            valid_q <= 1'b0;
            ovl_q   <= 1'b0;
            seg_q   <= '0;
        end else begin
            code_q  <= to_onehot(res.idx);
            valid_q <= cal_en;
            if (cal_en && !res.clean) begin
                ovl_q <= 1'b1;
            end
            if (!valid_q) begin
                seg_q <= seg_in;
            end
        end
    end

    assign code         = code_q;
    assign code_valid   = valid_q;
    assign overlap_seen = ovl_q;

    assert_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot(code));

    assert_seg_hold_R6: assert property (@(posedge clk) disable iff (rst)
        code_valid |=> $stable(seg_q));

    assert_seg_range_R7: assert property (@(posedge clk) disable iff (rst)
        seg_q <= SEGW'(NSEG - 1));

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        overlap_seen |=> overlap_seen);

    assert_flag_cause_R8: assert property (@(posedge clk) disable iff (rst)
        !overlap_seen && !cal_en |=> !overlap_seen);

endmodule

// File: tb/thermo_interval_det_bench.sv
module thermo_interval_det_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cal_en;
    logic [2:0]  seg_sel;
    logic [62:0] therm;
    logic [15:0] code;
    logic        code_valid;
    logic        overlap_seen;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [15:0] m_code;
    logic        m_valid;
    logic        m_ovl;
    int          m_seg;

    always #5 clk = ~clk;

    thermo_interval_det u_thermo_interval_det (
        .clk          (clk),
        .rst          (rst),
        .cal_en       (cal_en),
        .seg_sel      (seg_sel),
        .therm        (therm),
        .code         (code),
        .code_valid   (code_valid),
        .overlap_seen (overlap_seen)
    );

    function automatic logic [62:0] glob(input int lvl);
        logic [63:0] v;
        v = (64'd1 << lvl) - 64'd1;
        return v[62:0];
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model(input logic r, input logic c, input int s,
                         input logic [62:0] t);
        int start;
        int cnt;
        bit clean;
        if (r) begin
            m_code = 16'h0001; m_valid = 1'b0; m_ovl = 1'b0; m_seg = 0;
        end else begin
            start = m_seg * 15;
            if (start > 47) start = 47;
            cnt = 0;
            for (int i = 0; i < 16; i++) cnt += int'(t[start + i]);
            clean = 1'b1;
            for (int i = 0; i < 16; i++) begin
                if (t[start + i] != (i < cnt)) clean = 1'b0;
            end
            m_code = 16'd1 << ((cnt > 15) ? 15 : cnt);
            if (c && !clean) m_ovl = 1'b1;
            if (!m_valid) m_seg = (s > 4) ? 4 : s;
            m_valid = c;
        end
    endtask

    task automatic step(input logic r, input logic c, input int s,
                        input logic [62:0] t, input string tag);
        rst = r; cal_en = c; seg_sel = 3'(s); therm = t;
        @(posedge clk);
        model(r, c, s, t);
        #2;
        chk(tag, "code", code, m_code);
        chk(tag, "valid", {15'd0, code_valid}, {15'd0, m_valid});
        chk(tag, "overlap", {15'd0, overlap_seen}, {15'd0, m_ovl});
        if (!r) chk("R9", "onehot", 16'($countones(code)), 16'd1);
    endtask

    initial begin
        // R1: reset state
        step(1'b1, 1'b0, 0, '0, "R1");
        step(1'b1, 1'b1, 3, '1, "R1");
        chk("R1", "code_rst", code, 16'h0001);

        // R3: every clean level inside window 0, including full window
        for (int k = 0; k <= 16; k++) step(1'b0, 1'b1, 0, glob(k), "R3");
        step(1'b0, 1'b1, 0, glob(40), "R3");
        chk("R3", "full_window", code, 16'h8000);

        // R5: strobe follows cal_en one cycle later
        step(1'b0, 1'b0, 0, glob(5), "R5");
        chk("R5", "valid_low", {15'd0, code_valid}, 16'd0);
        step(1'b0, 1'b1, 0, glob(6), "R5");
        chk("R5", "code_lvl6", code, 16'h0040);

        // R2: move window while strobe is low
        step(1'b0, 1'b0, 2, glob(35), "R2");
        step(1'b0, 1'b0, 2, glob(35), "R2");
        step(1'b0, 1'b1, 2, glob(38), "R2");
        chk("R2", "seg2_lvl38", code, 16'h0100);
        step(1'b0, 1'b1, 2, glob(30), "R2");
        step(1'b0, 1'b1, 2, glob(46), "R2");
        step(1'b0, 1'b1, 2, glob(29), "R2");

        // R6: seg_sel toggles are ignored while strobed
        step(1'b0, 1'b1, 0, glob(40), "R6");
        chk("R6", "still_seg2", code, 16'h0400);
        step(1'b0, 1'b1, 1, glob(20), "R6");
        step(1'b0, 1'b1, 3, glob(33), "R6");

        // R7: out of range segment selects top window
        step(1'b0, 1'b0, 7, glob(10), "R7");
        step(1'b0, 1'b0, 7, glob(10), "R7");
        step(1'b0, 1'b1, 7, glob(55), "R7");
        chk("R7", "top_lvl55", code, 16'h0100);
        step(1'b0, 1'b1, 7, glob(63), "R7");
        step(1'b0, 1'b1, 7, glob(47), "R7");

        // R8: bubble outside calibration leaves the flag clear
        step(1'b0, 1'b0, 7, glob(50) ^ (63'd1 << 48), "R8");
        step(1'b0, 1'b0, 7, glob(50) ^ (63'd1 << 60), "R8");
        chk("R8", "flag_clear", {15'd0, overlap_seen}, 16'd0);

        // R4: corrupted windows in calibration
        step(1'b0, 1'b1, 7, glob(50) ^ (63'd1 << 52), "R4");
        chk("R8", "flag_set", {15'd0, overlap_seen}, 16'd1);
        step(1'b0, 1'b1, 7, glob(47) | (63'd1 << 62), "R4");
        step(1'b0, 1'b1, 7, (glob(63) ^ (63'd1 << 47)), "R4");
        for (int i = 0; i < 20; i++)
            step(1'b0, 1'b1, 7, {$urandom, $urandom}, "R4");
        step(1'b0, 1'b1, 7, glob(52), "R8");
        chk("R8", "flag_sticky", {15'd0, overlap_seen}, 16'd1);

        // Reset clears the flag, then mixed traffic
        step(1'b1, 1'b0, 0, '0, "R1");
        for (int i = 0; i < 400; i++) begin
            if ($urandom % 2 == 0)
                step(1'b0, 1'($urandom % 4 != 0), int'($urandom % 8),
                     glob(int'($urandom % 64)), "R9");
            else
                step(1'b0, 1'($urandom % 4 != 0), int'($urandom % 8),
                     {$urandom, $urandom}, "R9");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule